// File: doc/BRIEF.md
# Strided ATA Register Window Bridge

This block is a memory-mapped slave. It turns a 4 KB window on a simple bus into accesses on the register port of an attached ATA device model. Bits 11:4 of the bus address select a register, so consecutive registers sit 16 bytes apart. Address bits above the window are ignored, so the register set repeats every 4 KB. The block holds no register contents of its own. Every mapped access passes straight through to the device in the same cycle, and all storage lives in that device.

The access width comes in on a 2-bit size input. Byte accesses reach the seven task-file registers and the device-control / alternate-status register. That register has two aliases in the window. Halfword and word accesses reach only the data register. Their bytes are reordered in both directions, because the bus and the device use opposite byte orders. An access that maps to nothing reads as all ones at the width of the access, and a write to it is dropped. Read data returns on the cycle after the read strobe, marked by a valid flag. A byte read of the task-file status register also raises an acknowledge pulse, which the device can use to clear its pending interrupt. A read of the alternate status register does not raise it.

Top module: `ide_win_bridge`

## Requirements
- R1: The register index is bus address bits 11:4. Address bits 3:0 and all bits above bit 11 have no effect on decoding.
- R2: A byte access (size 0) at index 1 to 7 strobes the device with register code equal to the index. A write drives bus data bits 7:0 on device data bits 7:0 with the upper bits zero. A read returns device data bits 7:0 with the upper 24 bits zero.
- R3: A byte access at index 8 or at index 22 strobes the device with register code 8. A write there reaches device control, and a read returns alternate status.
- R4: A byte read at any other index (including 0) returns 0x000000FF. A byte write there raises no device strobe.
- R5: A halfword (size 1) or word (size 2) access strobes the device only at index 0, with register code 0 and device size equal to the bus size. At other indices, a halfword read returns 0x0000FFFF and a word read returns 0xFFFFFFFF. Size 3 is reserved: it never strobes the device and reads 0xFFFFFFFF. Writes that do not map raise no strobe.
- R6: A halfword transfer swaps the two low bytes in both directions, and the upper 16 bits are zero on both sides.
- R7: A word transfer reverses all four bytes in both directions (bits 7:0 trade places with bits 31:24, and bits 15:8 with bits 23:16).
- R8: The read-valid output is high exactly on the cycle after a read strobe. The read data stays unchanged until the next read.
- R9: The status-acknowledge output pulses together with read-valid only for a byte read at index 7. A read at index 8 or 22 does not raise it.
- R10: While reset is low, read-valid and status-acknowledge are low and the read data is zero. Reset acts asynchronously.
- R11: If read and write strobes arrive in the same cycle, only the write goes to the device, and no read-valid follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Bus byte address |
| bus_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, held between reads |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| dev_reg_o | output | 4 | Device register code: 0 data, 1 to 7 task file, 8 control/alt status |
| dev_size_o | output | 2 | Access size forwarded to the device |
| dev_wr_o | output | 1 | Device write strobe |
| dev_rd_o | output | 1 | Device read strobe |
| dev_wdata_o | output | 32 | Device write data in device byte order |
| dev_rdata_i | input | 32 | Device read data, valid in the strobe cycle |
| stat_ack_o | output | 1 | Status-read acknowledge pulse |

## Verification
A wrong index decode shows up in the same cycle as a strobe on the device port that is missing, misplaced or carries the wrong register code. It is caught directly at the window edges: indices 0, 8, 22 and 255, and the 4 KB alias. An error in lane steering or byte order shows on the device write data in the same cycle, or on the read data one cycle later. The device data register carries four distinct bytes, so any misplaced lane shows up. A fault in the response register shows as a valid flag or acknowledge pulse on the wrong cycle, or as read data that drifts while the bus is idle.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TASK = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_DATA = 2'd3
  } tgt_e;

  localparam int unsigned DEV_REG_W = 4;
  localparam logic [DEV_REG_W-1:0] DEV_REG_DATA = 4'd0;
  localparam logic [DEV_REG_W-1:0] DEV_REG_CTRL = 4'd8;
endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_win_pkg::*;
#(
  parameter int unsigned WIN_BITS    = 12,
  parameter int unsigned STRIDE_BITS = 4,
  parameter int unsigned TF_FIRST    = 1,
  parameter int unsigned TF_LAST     = 7,
  parameter int unsigned STATUS_IDX  = 7,
  parameter int unsigned CTRL_IDX_A  = 8,
  parameter int unsigned CTRL_IDX_B  = 22,
  localparam int unsigned IDX_W      = WIN_BITS - STRIDE_BITS
) (
  input  logic [WIN_BITS-1:0]  win_addr_i,
  input  logic [1:0]           size_i,
  output tgt_e                 tgt_o,
  output logic [DEV_REG_W-1:0] reg_o,
  output logic                 is_status_o
);
  localparam logic [IDX_W-1:0] IDX_TF_LO  = IDX_W'(TF_FIRST);
  localparam logic [IDX_W-1:0] IDX_TF_HI  = IDX_W'(TF_LAST);
  localparam logic [IDX_W-1:0] IDX_STAT   = IDX_W'(STATUS_IDX);
  localparam logic [IDX_W-1:0] IDX_CTRL_A = IDX_W'(CTRL_IDX_A);
  localparam logic [IDX_W-1:0] IDX_CTRL_B = IDX_W'(CTRL_IDX_B);

  logic [IDX_W-1:0] idx;
  logic             tf_range;

  assign idx      = win_addr_i[WIN_BITS-1:STRIDE_BITS];
  assign tf_range = (idx >= IDX_TF_LO) && (idx <= IDX_TF_HI);

  always_comb begin
    tgt_o = TGT_NONE;
    reg_o = DEV_REG_DATA;
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin
        if (tf_range) begin
          tgt_o = TGT_TASK;
          reg_o = idx[DEV_REG_W-1:0];
        end else if (idx == IDX_CTRL_A || idx == IDX_CTRL_B) begin
          tgt_o = TGT_CTRL;
          reg_o = DEV_REG_CTRL;
        end
      end
      SZ_HALF, SZ_WORD: begin
        if (idx == '0) tgt_o = TGT_DATA;
      end
      default: tgt_o = TGT_NONE;
    endcase
  end

  assign is_status_o = (tgt_o == TGT_TASK) && (idx == IDX_STAT);
endmodule

// File: rtl/ide_win_swap.sv
module ide_win_swap
  import ide_win_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB    = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] full_rev;
  logic [DATA_W-1:0] half_rev;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign full_rev[8*i +: 8] = data_i[8*(NB-1-i) +: 8];
  end

  assign half_rev = {{(DATA_W-16){1'b0}}, data_i[7:0], data_i[15:8]};

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_HALF: data_o = half_rev;
      SZ_WORD: data_o = full_rev;
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/ide_win_resp.sv
module ide_win_resp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      ack_o   <= 1'b0;
    end else begin
      valid_o <= load_i;
      ack_o   <= load_i && ack_i;
      if (load_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/ide_win_bridge.sv
module ide_win_bridge
  import ide_win_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WIN_BITS    = 12,
  parameter int unsigned STRIDE_BITS = 4,
  localparam int unsigned DATA_W     = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [1:0]           bus_size_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 bus_rvalid_o,
  output logic [DEV_REG_W-1:0] dev_reg_o,
  output logic [1:0]           dev_size_o,
  output logic                 dev_wr_o,
  output logic                 dev_rd_o,
  output logic [DATA_W-1:0]    dev_wdata_o,
  input  logic [DATA_W-1:0]    dev_rdata_i,
  output logic                 stat_ack_o
);
  tgt_e              tgt;
  logic              is_status;
  logic              hit;
  logic              rd_req;
  logic [DATA_W-1:0] wdata_sw;
  logic [DATA_W-1:0] rdata_sw;
  logic [DATA_W-1:0] rdata_next;
  logic              unused_addr;

  assign unused_addr = ^{bus_addr_i[ADDR_W-1:WIN_BITS], bus_addr_i[STRIDE_BITS-1:0]};

  ide_win_decode #(
    .WIN_BITS    (WIN_BITS),
    .STRIDE_BITS (STRIDE_BITS)
  ) u_dec (
    .win_addr_i  (bus_addr_i[WIN_BITS-1:0]),
    .size_i      (bus_size_i),
    .tgt_o       (tgt),
    .reg_o       (dev_reg_o),
    .is_status_o (is_status)
  );

  ide_win_swap #(.DATA_W(DATA_W)) u_swap_wr (
    .data_i (bus_wdata_i),
    .size_i (bus_size_i),
    .data_o (wdata_sw)
  );

  ide_win_swap #(.DATA_W(DATA_W)) u_swap_rd (
    .data_i (dev_rdata_i),
    .size_i (bus_size_i),
    .data_o (rdata_sw)
  );

  assign hit    = (tgt != TGT_NONE);
  // write wins a same-cycle collision
  assign rd_req = bus_rd_i && !bus_wr_i;

  assign dev_wr_o   = bus_wr_i && hit;
  assign dev_rd_o   = rd_req && hit;
  assign dev_size_o = bus_size_i;

  always_comb begin
    unique case (tgt)
      TGT_DATA:           dev_wdata_o = wdata_sw;
      TGT_TASK, TGT_CTRL: dev_wdata_o = {{(DATA_W-8){1'b0}}, bus_wdata_i[7:0]};
      default:            dev_wdata_o = '0;
    endcase
  end

  always_comb begin
    unique case (tgt)
      TGT_DATA:           rdata_next = rdata_sw;
      TGT_TASK, TGT_CTRL: rdata_next = {{(DATA_W-8){1'b0}}, dev_rdata_i[7:0]};
      default: begin
        unique case (acc_size_e'(bus_size_i))
          SZ_BYTE: rdata_next = {{(DATA_W-8){1'b0}}, 8'hFF};
          SZ_HALF: rdata_next = {{(DATA_W-16){1'b0}}, 16'hFFFF};
          default: rdata_next = '1;
        endcase
      end
    endcase
  end

  ide_win_resp #(.DATA_W(DATA_W)) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rd_req),
    .data_i  (rdata_next),
    .ack_i   (is_status),
    .data_o  (bus_rdata_o),
    .valid_o (bus_rvalid_o),
    .ack_o   (stat_ack_o)
  );
endmodule

// File: rtl/ide_win_bridge_chk.sv
module ide_win_bridge_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WIN_BITS    = 12,
  parameter int unsigned STRIDE_BITS = 4,
  localparam int unsigned IDX_W      = WIN_BITS - STRIDE_BITS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [1:0]        bus_size_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              bus_rvalid_o,
  input logic [3:0]        dev_reg_o,
  input logic [1:0]        dev_size_o,
  input logic              dev_wr_o,
  input logic              dev_rd_o,
  input logic [31:0]       dev_wdata_o,
  input logic [31:0]       dev_rdata_i,
  input logic              stat_ack_o
);
  logic [IDX_W-1:0] idx;
  logic             byte_mapped;
  logic             rd_only;
  logic             unused_chk;

  assign idx         = bus_addr_i[WIN_BITS-1:STRIDE_BITS];
  assign byte_mapped = (idx >= 1 && idx <= 8) || idx == 22;
  assign rd_only     = bus_rd_i && !bus_wr_i;
  assign unused_chk  = ^{bus_wdata_i, dev_wdata_i_sink(dev_wdata_o), dev_rdata_i, dev_size_o};

  function automatic logic dev_wdata_i_sink(input logic [31:0] v);
    return ^v;
  endfunction

  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_only |=> bus_rvalid_o); // R8
  AST_RVALID_NEEDS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> $past(rd_only)); // R8
  AST_ACK_ONLY_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_ack_o |-> $past(rd_only && bus_size_i == 2'd0 && idx == 7)); // R9
  AST_ACK_WITH_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_ack_o |-> bus_rvalid_o); // R9
  AST_NO_DUAL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_wr_o && dev_rd_o)); // R11
  AST_UNMAPPED_BYTE_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_only && bus_size_i == 2'd0 && !byte_mapped) |=> bus_rdata_o == 32'h0000_00FF); // R4
  AST_WIDE_ONLY_IDX0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dev_wr_o || dev_rd_o) && bus_size_i != 2'd0) |-> (idx == 0 && bus_size_i != 2'd3 && dev_reg_o == 4'd0)); // R5
  AST_CTRL_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dev_wr_o || dev_rd_o) && bus_size_i == 2'd0 && (idx == 8 || idx == 22)) |-> dev_reg_o == 4'd8); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_only |=> $stable(bus_rdata_o)); // R8
endmodule

bind ide_win_bridge ide_win_bridge_chk #(
  .ADDR_W      (ADDR_W),
  .WIN_BITS    (WIN_BITS),
  .STRIDE_BITS (STRIDE_BITS)
) u_chk (.*);

// File: tb/ide_win_bridge_tb_top.sv
`timescale 1ns/1ps
module ide_win_bridge_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic [1:0]  bus_size_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        bus_rvalid_o;
  logic [3:0]  dev_reg_o;
  logic [1:0]  dev_size_o;
  logic        dev_wr_o;
  logic        dev_rd_o;
  logic [31:0] dev_wdata_o;
  logic [31:0] dev_rdata_i;
  logic        stat_ack_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk_i = ~clk_i;

  // device model: data register has four distinct bytes, others 0x50+code with junk above
  always_comb begin
    if (dev_reg_o == 4'd0) dev_rdata_i = 32'h1122_3344;
    else                   dev_rdata_i = {24'hDEADBE, 8'h50 + {4'd0, dev_reg_o}};
  end

  ide_win_bridge dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // op[88] size[87:86] addr[85:70] wdata[69:38] exp[37:6] hit[5] reg[4:1] ack[0]
  localparam int NV = 20;
  localparam logic [88:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h0010, 32'h0,         32'h0000_0051, 1'b1, 4'd1, 1'b0},
    {1'b0, 2'd0, 16'h0070, 32'h0,         32'h0000_0057, 1'b1, 4'd7, 1'b1},
    {1'b0, 2'd0, 16'h0080, 32'h0,         32'h0000_0058, 1'b1, 4'd8, 1'b0},
    {1'b0, 2'd0, 16'h0160, 32'h0,         32'h0000_0058, 1'b1, 4'd8, 1'b0},
    {1'b0, 2'd0, 16'h0000, 32'h0,         32'h0000_00FF, 1'b0, 4'd0, 1'b0},
    {1'b0, 2'd0, 16'h0090, 32'h0,         32'h0000_00FF, 1'b0, 4'd0, 1'b0},
    {1'b0, 2'd0, 16'h0FF0, 32'h0,         32'h0000_00FF, 1'b0, 4'd0, 1'b0},
    {1'b0, 2'd0, 16'h1070, 32'h0,         32'h0000_0057, 1'b1, 4'd7, 1'b1},
    {1'b0, 2'd0, 16'h007C, 32'h0,         32'h0000_0057, 1'b1, 4'd7, 1'b1},
    {1'b0, 2'd1, 16'h0000, 32'h0,         32'h0000_4433, 1'b1, 4'd0, 1'b0},
    {1'b0, 2'd2, 16'h0000, 32'h0,         32'h4433_2211, 1'b1, 4'd0, 1'b0},
    {1'b0, 2'd1, 16'h0010, 32'h0,         32'h0000_FFFF, 1'b0, 4'd0, 1'b0},
    {1'b0, 2'd2, 16'h0070, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd0, 1'b0},
    {1'b0, 2'd3, 16'h0000, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd0, 1'b0},
    {1'b1, 2'd0, 16'h0020, 32'hAABB_CC3C, 32'h0000_003C, 1'b1, 4'd2, 1'b0},
    {1'b1, 2'd0, 16'h0160, 32'h0000_0004, 32'h0000_0004, 1'b1, 4'd8, 1'b0},
    {1'b1, 2'd0, 16'h00A0, 32'h0000_0012, 32'h0000_0000, 1'b0, 4'd0, 1'b0},
    {1'b1, 2'd1, 16'h0000, 32'h9999_ABCD, 32'h0000_CDAB, 1'b1, 4'd0, 1'b0},
    {1'b1, 2'd2, 16'h0000, 32'h0123_4567, 32'h6745_2301, 1'b1, 4'd0, 1'b0},
    {1'b1, 2'd2, 16'h0040, 32'h0000_0001, 32'h0000_0000, 1'b0, 4'd0, 1'b0}
  };
  localparam string TAG [NV] = '{
    "R2", "R9", "R3", "R3", "R4", "R4", "R4", "R1", "R1", "R6",
    "R7", "R5", "R5", "R5", "R2", "R3", "R4", "R6", "R7", "R5"
  };

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk_i);
    chk("R10 rvalid in reset", {31'd0, bus_rvalid_o}, 32'd0);
    chk("R10 ack in reset", {31'd0, stat_ack_o}, 32'd0);
    chk("R10 rdata in reset", bus_rdata_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      logic        op, hit, ack;
      logic [1:0]  sz;
      logic [3:0]  rg;
      logic [31:0] exp;
      op = VEC[v][88]; sz = VEC[v][87:86]; exp = VEC[v][37:6];
      hit = VEC[v][5]; rg = VEC[v][4:1]; ack = VEC[v][0];
      bus_addr_i  = {16'h0, VEC[v][85:70]};
      bus_size_i  = sz;
      bus_wdata_i = VEC[v][69:38];
      bus_wr_i    = op;
      bus_rd_i    = !op;
      #1;
      if (op) begin
        chk({TAG[v], " dev_wr"}, {31'd0, dev_wr_o}, {31'd0, hit});
        chk({TAG[v], " dev_rd"}, {31'd0, dev_rd_o}, 32'd0);
        if (hit) chk({TAG[v], " dev_wdata"}, dev_wdata_o, exp);
      end else begin
        chk({TAG[v], " dev_rd"}, {31'd0, dev_rd_o}, {31'd0, hit});
        chk({TAG[v], " dev_wr"}, {31'd0, dev_wr_o}, 32'd0);
      end
      if (hit) begin
        chk({TAG[v], " dev_reg"}, {28'd0, dev_reg_o}, {28'd0, rg});
        chk({TAG[v], " dev_size"}, {30'd0, dev_size_o}, {30'd0, sz});
      end
      @(posedge clk_i); #1;
      chk({TAG[v], " R8 rvalid"}, {31'd0, bus_rvalid_o}, {31'd0, !op});
      chk({TAG[v], " R9 ack"}, {31'd0, stat_ack_o}, {31'd0, ack});
      if (!op) chk({TAG[v], " rdata"}, bus_rdata_o, exp);
      @(negedge clk_i);
      bus_wr_i = 1'b0; bus_rd_i = 1'b0;
    end

    // R8: single-cycle valid and held data
    bus_addr_i = 32'h0; bus_size_i = 2'd2; bus_rd_i = 1'b1;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
    chk("R8 rvalid after word read", {31'd0, bus_rvalid_o}, 32'd1);
    bus_addr_i = 32'h10; bus_size_i = 2'd0;
    @(negedge clk_i);
    chk("R8 rvalid drops", {31'd0, bus_rvalid_o}, 32'd0);
    @(negedge clk_i);
    chk("R8 rdata held", bus_rdata_o, 32'h4433_2211);

    // R11: read and write together
    bus_addr_i = 32'h10; bus_size_i = 2'd0; bus_wdata_i = 32'h77;
    bus_wr_i = 1'b1; bus_rd_i = 1'b1;
    #1;
    chk("R11 dev_wr", {31'd0, dev_wr_o}, 32'd1);
    chk("R11 dev_rd", {31'd0, dev_rd_o}, 32'd0);
    chk("R11 dev_wdata", dev_wdata_o, 32'h77);
    @(negedge clk_i);
    bus_wr_i = 1'b0; bus_rd_i = 1'b0;
    chk("R11 no rvalid", {31'd0, bus_rvalid_o}, 32'd0);

    // R10: asynchronous reset clears a pending response
    bus_addr_i = 32'h70; bus_rd_i = 1'b1;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
    chk("R9 ack before reset", {31'd0, stat_ack_o}, 32'd1);
    #0.5 rst_ni = 1'b0;
    #0.5;
    chk("R10 async rvalid", {31'd0, bus_rvalid_o}, 32'd0);
    chk("R10 async ack", {31'd0, stat_ack_o}, 32'd0);
    chk("R10 async rdata", bus_rdata_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule